// File: doc/BRIEF.md
# Bus Master Tenure Limiter

This block sits inside a DMA engine that masters a system bus. While the engine moves FIFO data to or from memory it watches two budgets. The first is the number of data transfers made since the engine last won the bus. The second is an optional elapsed-time budget counted in 0.1 µs ticks, where a tick is a fixed number of clock cycles set by a parameter. When either budget is used up, the block raises a request that tells the engine to give the bus back.

Descriptor traffic is never counted or timed, and the release request stays low while it runs. When linear bursting is on, an exhausted budget does not end the tenure in the middle of a burst. The request waits until the address of the next transfer falls on a burst boundary. Both limit registers can be written only while the engine is stopped. A hard reset or a soft reset puts a transfer limit of 16 back in place.

The engine pulses `tenure_start_i` each time it gains the bus. It strobes `xfer_i` once per completed transfer and presents on `addr_i` the address of the next transfer it would issue. It samples `release_o` before it starts each transfer.

Top module: `tenure_limiter`

## Requirements
- R1: After `rst_n` low or a `soft_rst_i` pulse the transfer limit is 16, so `release_o` rises after 16 data transfers; `release_o` is 0 out of reset.
- R2: A transfer limit of 0 behaves exactly like a limit of 1.
- R3: A write to the transfer limit or the time limit takes effect only in a cycle where `stop_i` is 1. Raising or lowering `stop_i` without a write leaves both limits unchanged.
- R4: While `unlim_i` is 1 the transfer count never causes a release.
- R5: A transfer with `desc_i` = 1 is not counted. The tick prescaler and the elapsed-time count hold while `desc_i` is 1, and `release_o` is 0 whenever `desc_i` is 1.
- R6: With `timer_en_i` = 1 and time limit L, the elapsed-tick count rises by one every TICK_DIV data-phase clock edges. `release_o` rises right after the edge at which that count reaches L.
- R7: While `timer_en_i` is 0 the time limit never causes a release.
- R8: With `lb_en_i` = 1 an exhausted budget releases only while the low log2(BUS_BYTES)+`lb_size_i` bits of `addr_i` are all zero. The burst length in transfers is 2 to the power `lb_size_i`. With `lb_en_i` = 0 the address plays no part.
- R9: `tenure_start_i` clears the transfer count, the prescaler and the elapsed-tick count. A data transfer strobed in the same cycle counts as the first transfer of the new tenure.
- R10: Once a budget is exhausted, `release_o` stays 1 (with `desc_i` = 0 and the alignment of R8 met) until the next `tenure_start_i`. It is a combinational function of the registered counts and the current `desc_i` and `addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| soft_rst_i | input | 1 | Soft reset: reloads the transfer limit with 16 |
| stop_i | input | 1 | Engine stopped; enables limit register writes |
| cnt_wr_i | input | 1 | Write strobe for the transfer limit |
| cnt_wr_data_i | input | CNT_W | Transfer limit write value |
| tim_wr_i | input | 1 | Write strobe for the time limit |
| tim_wr_data_i | input | TIME_W | Time limit write value, in ticks |
| unlim_i | input | 1 | Disables the transfer count limit |
| timer_en_i | input | 1 | Enables the time limit |
| lb_en_i | input | 1 | Linear burst mode enable |
| lb_size_i | input | 3 | Burst length code: 2^code transfers |
| tenure_start_i | input | 1 | Pulse at the start of each bus ownership period |
| xfer_i | input | 1 | One transfer completes this cycle |
| desc_i | input | 1 | Current traffic is a descriptor access |
| addr_i | input | ADDR_W | Byte address of the next transfer |
| release_o | output | 1 | Request to give up the bus |

## Verification
The bench builds the block with TICK_DIV = 4, ADDR_W = 16 and BUS_BYTES = 4. The short tick lets a time budget of a few ticks expire within a dozen or two cycles, and each tick boundary can be checked on the exact edge. The 16-bit address still covers the widest burst code, 7 (512 bytes), so the longest deferral can be seen. Transfer limits are run up to 255 in full, and the zero and one limits are run at the low end.

// File: rtl/tenure_pkg.sv
// Shared constants and helpers for the bus tenure limiter.
// Assumes: transfer limit register is 8 bits wide by default.
package tenure_pkg;

    // Value loaded into the transfer limit on hard or soft reset.
    localparam int unsigned CNT_RESET_VAL = 16;

    // Width of the linear burst size code.
    localparam int unsigned LB_CODE_W = 3;

    // Effective transfer limit: a programmed zero means one transfer.
    function automatic logic [7:0] eff_limit8(input logic [7:0] lim);
        return (lim == 8'd0) ? 8'd1 : lim;
    endfunction

endpackage

// File: rtl/tl_limit_regs.sv
// Holds the transfer-limit and time-limit registers.
// Writes land only while the engine is stopped; hard and soft reset
// reload the transfer limit, the time limit only clears on hard reset.
module tl_limit_regs #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned TIME_W  = 16,
    parameter int unsigned CNT_RST = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_i,
    input  logic              stop_i,
    input  logic              cnt_wr_i,
    input  logic [CNT_W-1:0]  cnt_wr_data_i,
    input  logic              tim_wr_i,
    input  logic [TIME_W-1:0] tim_wr_data_i,
    output logic [CNT_W-1:0]  cnt_limit_o,
    output logic [TIME_W-1:0] time_limit_o
);
    localparam logic [CNT_W-1:0] CNT_RST_V = CNT_W'(CNT_RST);

    // Transfer limit register: reset value on either reset, else gated write.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i) begin
            cnt_limit_o <= CNT_RST_V;
        end else if (stop_i && cnt_wr_i) begin
            cnt_limit_o <= cnt_wr_data_i;
        end
    end

    // Time limit register: cleared on hard reset, else gated write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_limit_o <= '0;
        end else if (stop_i && tim_wr_i) begin
            time_limit_o <= tim_wr_data_i;
        end
    end

    AST_SOFT_RST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (cnt_limit_o == CNT_RST_V)); // R1
    AST_CNT_LIM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_i && !soft_rst_i) |=> $stable(cnt_limit_o)); // R3
    AST_TIME_LIM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_i |=> $stable(time_limit_o)); // R3

endmodule

// File: rtl/tl_xfer_counter.sv
// Counts FIFO data transfers within one bus tenure and flags when the
// programmed limit is reached. Descriptor transfers are not counted.
// Assumes: tenure_start_i is a single-cycle pulse per ownership period.
module tl_xfer_counter
    import tenure_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tenure_start_i,
    input  logic             xfer_i,
    input  logic             desc_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             unlim_i,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             data_xfer;
    logic [CNT_W-1:0] eff_lim;

    // A transfer is counted only outside descriptor phases.
    assign data_xfer = xfer_i && !desc_i;

    // Zero limit means one transfer.
    assign eff_lim = (limit_i == '0) ? ONE : limit_i;

    // Saturating transfer counter, restarted at each new tenure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tenure_start_i) begin
            cnt_q <= data_xfer ? ONE : '0;
        end else if (data_xfer && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // Limit reached flag, suppressed in unlimited mode.
    assign hit_o = !unlim_i && (cnt_q >= eff_lim);

    AST_DESC_NOT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_i && !tenure_start_i) |=> $stable(cnt_q)); // R5
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tenure_start_i && !xfer_i) |=> (cnt_q == '0)); // R9
    AST_CNT_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !tenure_start_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + ONE)); // R9

endmodule

// File: rtl/tl_time_budget.sv
// Measures data-phase time within one tenure in ticks of TICK_DIV clocks
// and flags when the programmed time limit is reached.
// Assumes: TICK_DIV clocks equal one 0.1 us tick; time stops in descriptor phases.
module tl_time_budget #(
    parameter int unsigned TIME_W   = 16,
    parameter int unsigned TICK_DIV = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tenure_start_i,
    input  logic              desc_i,
    input  logic              timer_en_i,
    input  logic [TIME_W-1:0] limit_i,
    output logic              hit_o
);
    localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(TICK_DIV - 1);
    localparam logic [TIME_W-1:0] T_MAX    = '1;

    logic [PRE_W-1:0]  pre_q;
    logic [TIME_W-1:0] elapsed_q;
    logic              tick;

    // One tick per TICK_DIV running clocks.
    assign tick = !desc_i && (pre_q == PRE_LAST);

    // Prescaler: restarts at tenure start, holds during descriptor phases.
    always_ff @(posedge clk) begin
        if (!rst_n || tenure_start_i) begin
            pre_q <= '0;
        end else if (!desc_i) begin
            pre_q <= tick ? '0 : pre_q + PRE_W'(1);
        end
    end

    // Elapsed tick count: restarts at tenure start, saturates at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || tenure_start_i) begin
            elapsed_q <= '0;
        end else if (tick && (elapsed_q != T_MAX)) begin
            elapsed_q <= elapsed_q + TIME_W'(1);
        end
    end

    // Budget spent flag, only when the timer is enabled.
    assign hit_o = timer_en_i && (elapsed_q >= limit_i);

    AST_TIME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        tenure_start_i |=> (elapsed_q == '0) && (pre_q == '0)); // R9
    AST_TIME_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_i && !tenure_start_i) |=> $stable(elapsed_q) && $stable(pre_q)); // R5
    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_LAST); // R6

endmodule

// File: rtl/tl_burst_align.sv
// Decides whether the next transfer address is a legal burst start.
// With bursting off every address is legal; with it on the address must be
// aligned to BUS_BYTES times 2^size bytes.
module tl_burst_align #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BUS_BYTES = 4,
    parameter int unsigned CODE_W    = 3
) (
    input  logic              lb_en_i,
    input  logic [CODE_W-1:0] lb_size_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ok_o
);
    localparam int unsigned BUS_SH = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 0;

    logic [ADDR_W-1:0] must_be_zero;

    // Per address bit: does the current burst length demand it be zero.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        assign must_be_zero[b] = lb_en_i &&
            (b < (int'(BUS_SH) + int'(lb_size_i)));
    end

    // Legal start when no demanded bit is set.
    assign ok_o = ((addr_i & must_be_zero) == '0);

endmodule

// File: rtl/tenure_limiter.sv
// Top of the bus tenure limiter: combines the transfer-count and time
// budgets and raises a release request, deferred to a burst boundary in
// linear burst mode and held off during descriptor traffic.
// Assumes: addr_i is the address of the next transfer the engine would issue.
module tenure_limiter
    import tenure_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BUS_BYTES = 4,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned TIME_W    = 16,
    parameter int unsigned TICK_DIV  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_i,
    input  logic              stop_i,
    input  logic              cnt_wr_i,
    input  logic [CNT_W-1:0]  cnt_wr_data_i,
    input  logic              tim_wr_i,
    input  logic [TIME_W-1:0] tim_wr_data_i,
    input  logic              unlim_i,
    input  logic              timer_en_i,
    input  logic              lb_en_i,
    input  logic [2:0]        lb_size_i,
    input  logic              tenure_start_i,
    input  logic              xfer_i,
    input  logic              desc_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              release_o
);
    logic [CNT_W-1:0]  cnt_limit;
    logic [TIME_W-1:0] time_limit;
    logic              cnt_hit;
    logic              time_hit;
    logic              align_ok;
    logic              spent;

    tl_limit_regs #(
        .CNT_W   (CNT_W),
        .TIME_W  (TIME_W),
        .CNT_RST (CNT_RESET_VAL)
    ) regs_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst_i    (soft_rst_i),
        .stop_i        (stop_i),
        .cnt_wr_i      (cnt_wr_i),
        .cnt_wr_data_i (cnt_wr_data_i),
        .tim_wr_i      (tim_wr_i),
        .tim_wr_data_i (tim_wr_data_i),
        .cnt_limit_o   (cnt_limit),
        .time_limit_o  (time_limit)
    );

    tl_xfer_counter #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tenure_start_i (tenure_start_i),
        .xfer_i         (xfer_i),
        .desc_i         (desc_i),
        .limit_i        (cnt_limit),
        .unlim_i        (unlim_i),
        .hit_o          (cnt_hit)
    );

    tl_time_budget #(
        .TIME_W   (TIME_W),
        .TICK_DIV (TICK_DIV)
    ) tim_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tenure_start_i (tenure_start_i),
        .desc_i         (desc_i),
        .timer_en_i     (timer_en_i),
        .limit_i        (time_limit),
        .hit_o          (time_hit)
    );

    tl_burst_align #(
        .ADDR_W    (ADDR_W),
        .BUS_BYTES (BUS_BYTES),
        .CODE_W    (LB_CODE_W)
    ) align_i (
        .lb_en_i   (lb_en_i),
        .lb_size_i (lb_size_i),
        .addr_i    (addr_i),
        .ok_o      (align_ok)
    );

    // Either budget exhausted.
    assign spent = cnt_hit || time_hit;

    // Release only outside descriptor traffic and at a legal burst start.
    assign release_o = spent && !desc_i && align_ok;

    AST_DESC_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_i |-> !release_o); // R5
    AST_RELEASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (release_o && !tenure_start_i && !stop_i && !soft_rst_i) |=>
            (spent || $changed(unlim_i) || $changed(timer_en_i))); // R10

endmodule

// File: tb/tenure_limiter_tb_top.sv
`timescale 1ns/1ps
module tenure_limiter_tb_top;

    localparam int unsigned AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst_i = 1'b0;
    logic          stop_i = 1'b0;
    logic          cnt_wr_i = 1'b0;
    logic [7:0]    cnt_wr_data_i = '0;
    logic          tim_wr_i = 1'b0;
    logic [15:0]   tim_wr_data_i = '0;
    logic          unlim_i = 1'b0;
    logic          timer_en_i = 1'b0;
    logic          lb_en_i = 1'b0;
    logic [2:0]    lb_size_i = '0;
    logic          tenure_start_i = 1'b0;
    logic          xfer_i = 1'b0;
    logic          desc_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          release_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tenure_limiter #(
        .ADDR_W    (AW),
        .BUS_BYTES (4),
        .CNT_W     (8),
        .TIME_W    (16),
        .TICK_DIV  (4)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .soft_rst_i     (soft_rst_i),
        .stop_i         (stop_i),
        .cnt_wr_i       (cnt_wr_i),
        .cnt_wr_data_i  (cnt_wr_data_i),
        .tim_wr_i       (tim_wr_i),
        .tim_wr_data_i  (tim_wr_data_i),
        .unlim_i        (unlim_i),
        .timer_en_i     (timer_en_i),
        .lb_en_i        (lb_en_i),
        .lb_size_i      (lb_size_i),
        .tenure_start_i (tenure_start_i),
        .xfer_i         (xfer_i),
        .desc_i         (desc_i),
        .addr_i         (addr_i),
        .release_o      (release_o)
    );

    // Vector: limit, unlimited, burst on, burst code, start address,
    // expected transfers until release (0 = none within the cap).
    typedef struct packed {
        logic [7:0]  lim;
        logic        unl;
        logic        lbe;
        logic [2:0]  lbs;
        logic [15:0] start;
        logic [15:0] expn;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{8'd5,   1'b0, 1'b0, 3'd0, 16'h0000, 16'd5},   // R8 burst off
        '{8'd0,   1'b0, 1'b0, 3'd0, 16'h0000, 16'd1},   // R2 zero limit
        '{8'd1,   1'b0, 1'b0, 3'd0, 16'h0000, 16'd1},   // R2 one
        '{8'd3,   1'b0, 1'b1, 3'd2, 16'h0000, 16'd4},   // R8 deferral
        '{8'd8,   1'b0, 1'b1, 3'd2, 16'h0000, 16'd8},   // R8 aligned
        '{8'd5,   1'b0, 1'b1, 3'd3, 16'h0008, 16'd6},   // R8 offset start
        '{8'd255, 1'b0, 1'b0, 3'd0, 16'h0000, 16'd255}, // R7 max limit
        '{8'd2,   1'b1, 1'b0, 3'd0, 16'h0000, 16'd0},   // R4 unlimited
        '{8'd2,   1'b0, 1'b1, 3'd0, 16'h0004, 16'd2},   // R8 single-beat burst
        '{8'd1,   1'b0, 1'b1, 3'd7, 16'h01F0, 16'd4}    // R8 widest burst
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cnt(input logic [7:0] v, input logic with_stop);
        stop_i = with_stop; cnt_wr_i = 1'b1; cnt_wr_data_i = v;
        step();
        cnt_wr_i = 1'b0; stop_i = 1'b0;
    endtask

    task automatic write_tim(input logic [15:0] v, input logic with_stop);
        stop_i = with_stop; tim_wr_i = 1'b1; tim_wr_data_i = v;
        step();
        tim_wr_i = 1'b0; stop_i = 1'b0;
    endtask

    task automatic start_tenure();
        tenure_start_i = 1'b1;
        step();
        tenure_start_i = 1'b0;
        #1;
    endtask

    // Run transfers from start address until release or cap; returns count.
    task automatic run_burst(input logic [15:0] start, input int cap, output int n);
        start_tenure();
        addr_i = start; xfer_i = 1'b0; #1;
        n = 0;
        while (!release_o && n < cap) begin
            xfer_i = 1'b1;
            step();
            n++;
            addr_i = addr_i + 16'd4;
            xfer_i = 1'b0;
            #1;
        end
        if (!release_o) n = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 release low out of reset", int'(release_o), 0);
        run_burst(16'h0000, 300, n);
        chk("R1 default limit 16", n, 16);

        // Vector table walk, timer off (R7 covered by timer_en_i = 0).
        for (int i = 0; i < NV; i++) begin
            write_cnt(VEC[i].lim, 1'b1);
            unlim_i = VEC[i].unl; lb_en_i = VEC[i].lbe; lb_size_i = VEC[i].lbs;
            run_burst(VEC[i].start, 300, n);
            chk($sformatf("R2/R4/R8 vector %0d", i), n, int'(VEC[i].expn));
        end
        unlim_i = 1'b0; lb_en_i = 1'b0; lb_size_i = '0;

        // R1 soft reset reload
        write_cnt(8'd7, 1'b1);
        run_burst(16'h0000, 300, n);
        chk("R1 programmed 7", n, 7);
        soft_rst_i = 1'b1; step(); soft_rst_i = 1'b0;
        run_burst(16'h0000, 300, n);
        chk("R1 soft reset reload", n, 16);

        // R3 write ignored without stop; stop toggling alone changes nothing
        write_cnt(8'd3, 1'b0);
        run_burst(16'h0000, 300, n);
        chk("R3 write without stop ignored", n, 16);
        stop_i = 1'b1; repeat (3) step(); stop_i = 1'b0; step();
        run_burst(16'h0000, 300, n);
        chk("R3 stop toggle keeps limit", n, 16);

        // R5 descriptor transfers not counted
        write_cnt(8'd4, 1'b1);
        start_tenure();
        repeat (3) begin xfer_i = 1'b1; step(); end
        desc_i = 1'b1;
        repeat (10) step();
        chk("R5 no release during descriptors", int'(release_o), 0);
        xfer_i = 1'b0; desc_i = 1'b0; #1;
        chk("R5 descriptors not counted", int'(release_o), 0);
        xfer_i = 1'b1; step(); xfer_i = 1'b0; #1;
        chk("R5 fourth data transfer releases", int'(release_o), 1);

        // R10 release held until next tenure
        repeat (5) step();
        chk("R10 release held", int'(release_o), 1);
        start_tenure();
        chk("R10 cleared by tenure start", int'(release_o), 0);

        // R9 same-cycle start and transfer counts as first
        write_cnt(8'd3, 1'b1);
        tenure_start_i = 1'b1; xfer_i = 1'b1; step();
        tenure_start_i = 1'b0; step(); xfer_i = 1'b0; #1;
        chk("R9 two transfers below limit", int'(release_o), 0);
        xfer_i = 1'b1; step(); xfer_i = 1'b0; #1;
        chk("R9 start-cycle transfer counted", int'(release_o), 1);
        // R9 restart clears count
        start_tenure();
        repeat (2) begin xfer_i = 1'b1; step(); end
        xfer_i = 1'b0; #1;
        chk("R9 count restarted", int'(release_o), 0);

        // R6 time budget: limit 3 ticks of 4 clocks
        unlim_i = 1'b1;
        write_tim(16'd3, 1'b1);
        timer_en_i = 1'b1;
        start_tenure();
        repeat (11) step();
        chk("R6 before 12 clocks", int'(release_o), 0);
        step();
        chk("R6 at 12 clocks", int'(release_o), 1);

        // R5 timer paused during descriptors, limit 2
        write_tim(16'd2, 1'b1);
        desc_i = 1'b1;
        start_tenure();
        repeat (20) step();
        chk("R5 no release while descriptor", int'(release_o), 0);
        desc_i = 1'b0;
        repeat (7) step();
        chk("R5 timer paused in descriptor", int'(release_o), 0);
        step();
        chk("R6 release after 8 data clocks", int'(release_o), 1);

        // R3 time limit write without stop ignored (limit stays 2)
        write_tim(16'd40, 1'b0);
        start_tenure();
        repeat (8) step();
        chk("R3 time write without stop ignored", int'(release_o), 1);

        // R7 timer disabled
        timer_en_i = 1'b0;
        start_tenure();
        repeat (50) step();
        chk("R7 timer disabled", int'(release_o), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule